// File: doc/BRIEF.md
# Difference-of-Means Subkey Scorer

This block rates how well one 8-bit candidate subkey explains a set of recorded power traces. Each trace enters on a single valid/ready stream: one header beat whose low byte is the observed cipher output byte, then a fixed number of unsigned current samples. For every trace the block XORs the output byte with the candidate subkey and passes the result through the inverse AES S-box. The resulting selection value sorts the trace into one of two groups. The block then adds the trace's samples, position by position, into that group's running sums and counts the trace.

Two sorting rules are offered. The first takes one chosen bit of the selection value. The second splits on Hamming weight, and traces whose selection value has weight exactly four are dropped. When the trace set ends, the block walks all sample positions and finds the largest absolute difference of the two group means. It does this without a divider: it compares cross-multiplied sums and reports the numerator, the denominator and the position of the peak. A full attack on one S-box runs the block 256 times, once per candidate. The candidate loop and the ranking are left to the surrounding system.

Top module: `dom_key_scorer`

## Requirements
- R1: The selection value of a trace is InvSbox(b XOR k), where b is the low byte of the trace's header beat and k is `guess`. InvSbox is the standard inverse AES S-box, so InvSbox(0x63)=0x00, InvSbox(0x16)=0xFF and InvSbox(0x76)=0x0F.
- R2: With `hw_mode`=0, the trace goes to group 1 when selection bit `bit_sel` (0 = least significant) is 1, and to group 0 when that bit is 0.
- R3: With `hw_mode`=1, weights 0 to 3 go to group 0 and weights 5 to 8 go to group 1. A trace of weight 4 still consumes its beats but changes no sum and no count.
- R4: A `start` pulse zeroes both group counts and all per-position sums. `in_ready` is low for exactly NSAMP cycles after the edge that samples `start`, and high from then on.
- R5: A trace is one header beat followed by NSAMP sample beats. `set_end` is honoured only when the block is waiting for a header. A pulse during a trace's samples is ignored.
- R6: With n0 and n1 the group counts and S0(t) and S1(t) the group sums at position t, `score_num` is the maximum over t of |S0(t)·n1 − S1(t)·n0|. `score_den` is n0·n1, and `peak_idx` is the lowest t that reaches the maximum.
- R7: If n0 or n1 is zero, `invalid` is 1 and `score_num`, `peak_idx` and `score_den` are 0. Otherwise `invalid` is 0 and `score_den` is nonzero.
- R8: `done` is a one-cycle pulse that rises NSAMP+1 cycles after the edge that accepts `set_end`. The result outputs change only on that edge and then hold.
- R9: After reset, and from the end of a search until the next `start`, `in_ready` is low and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: clear accumulators and begin a trace set |
| set_end | input | 1 | Pulse between traces: begin the peak search |
| guess | input | 8 | Candidate subkey |
| bit_sel | input | 3 | Selection bit used in bit mode |
| hw_mode | input | 1 | 1 selects the Hamming-weight split |
| in_valid | input | 1 | Stream beat valid |
| in_data | input | SAMP_W | Header beat (low byte) or sample |
| in_ready | output | 1 | Stream beat accepted when high with in_valid |
| done | output | 1 | One-cycle pulse: result ready |
| invalid | output | 1 | A group ended empty |
| score_num | output | SUM_W+CNT_W | Peak cross-multiplied difference |
| score_den | output | 2*CNT_W | Product of the group counts |
| peak_idx | output | IDX_W | Sample position of the peak |

## Verification
The clear sweep is due NSAMP cycles after the `start` edge. The bench counts falling edges from that point until `in_ready` rises and compares the count exactly. The result is due NSAMP+1 cycles after the `set_end` edge. The bench counts cycles to `done` in the same way and reads every result output in that single cycle. It then looks once more a cycle later to confirm that the pulse has ended and the values hold. Inputs change only after a rising edge, and outputs are read at the falling edge, so every sample falls between register updates.

// File: rtl/dom_pkg.sv
package dom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_HDR,
    ST_SAMP,
    ST_SEARCH,
    ST_FIN
  } dom_state_e;

  // Multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  // Field inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

endpackage

// File: rtl/dom_inv_sbox.sv
module dom_inv_sbox
  import dom_pkg::*;
(
  input  logic [7:0] x,
  output logic [7:0] y
);

  logic [7:0] unaff;

  // Undo the affine step, then invert in the field
  always_comb begin
    unaff = {x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05;
    y     = gf_inv(unaff);
  end

endmodule

// File: rtl/dom_group_sel.sv
module dom_group_sel (
  input  logic [7:0] sel,
  input  logic       hw_mode,
  input  logic [2:0] bit_sel,
  output logic       member,
  output logic       grp
);

  logic [3:0] weight;

  always_comb begin
    weight = 4'd0;
    for (int i = 0; i < 8; i++) begin
      weight = weight + {3'd0, sel[i]};
    end
    if (hw_mode) begin
      member = (weight != 4'd4);
      grp    = (weight > 4'd4);
    end else begin
      member = 1'b1;
      grp    = sel[bit_sel];
    end
  end

endmodule

// File: rtl/dom_acc_bank.sv
module dom_acc_bank #(
  parameter int DEPTH = 500,
  parameter int W     = 32,
  parameter int IW    = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/dom_peak_unit.sv
module dom_peak_unit #(
  parameter int SUM_W = 32,
  parameter int CNT_W = 16,
  parameter int IW    = 9,
  parameter int NUM_W = SUM_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             first,
  input  logic [IW-1:0]    idx,
  input  logic [SUM_W-1:0] s0,
  input  logic [SUM_W-1:0] s1,
  input  logic [CNT_W-1:0] n0,
  input  logic [CNT_W-1:0] n1,
  output logic [NUM_W-1:0] best,
  output logic [IW-1:0]    best_idx
);

  logic [NUM_W-1:0] p0;
  logic [NUM_W-1:0] p1;
  logic [NUM_W-1:0] diff;
  logic             take;
  logic [NUM_W-1:0] best_q;
  logic [IW-1:0]    best_idx_q;

  always_comb begin
    p0   = NUM_W'(s0) * NUM_W'(n1);
    p1   = NUM_W'(s1) * NUM_W'(n0);
    diff = (p0 >= p1) ? (p0 - p1) : (p1 - p0);
    // strict compare keeps the earliest position on ties
    take = en && (first || (diff > best_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q     <= '0;
      best_idx_q <= '0;
    end else if (take) begin
      best_q     <= diff;
      best_idx_q <= idx;
    end
  end

  assign best     = best_q;
  assign best_idx = best_idx_q;

endmodule

// File: rtl/dom_key_scorer.sv
module dom_key_scorer
  import dom_pkg::*;
#(
  parameter int NSAMP  = 500,
  parameter int SAMP_W = 16,
  parameter int SUM_W  = 32,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(NSAMP),
  localparam int NUM_W = SUM_W + CNT_W,
  localparam int DEN_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              set_end,
  input  logic [7:0]        guess,
  input  logic [2:0]        bit_sel,
  input  logic              hw_mode,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_data,
  output logic              in_ready,
  output logic              done,
  output logic              invalid,
  output logic [NUM_W-1:0]  score_num,
  output logic [DEN_W-1:0]  score_den,
  output logic [IDX_W-1:0]  peak_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSAMP - 1);

  dom_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             grp_q, grp_d;
  logic             mem_q, mem_d;
  logic [CNT_W-1:0] n0_q, n0_d;
  logic [CNT_W-1:0] n1_q, n1_d;

  logic [7:0]       sel_val;
  logic             hdr_member;
  logic             hdr_grp;
  logic             clr_w;
  logic             acc_w;
  logic [SUM_W-1:0] rd_sum [2];
  logic [NUM_W-1:0] best;
  logic [IDX_W-1:0] best_idx;

  logic             done_q;
  logic             invalid_q;
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [IDX_W-1:0] pidx_q;
  logic             fin_en;
  logic             empty_grp;

  dom_inv_sbox u_inv (
    .x (in_data[7:0] ^ guess),
    .y (sel_val)
  );

  dom_group_sel u_sel (
    .sel     (sel_val),
    .hw_mode (hw_mode),
    .bit_sel (bit_sel),
    .member  (hdr_member),
    .grp     (hdr_grp)
  );

  assign in_ready = ((state_q == ST_HDR) && !set_end) || (state_q == ST_SAMP);
  assign clr_w    = (state_q == ST_CLEAR);
  assign acc_w    = (state_q == ST_SAMP) && in_valid && mem_q;

  // next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    grp_d   = grp_q;
    mem_d   = mem_q;
    n0_d    = n0_q;
    n1_d    = n1_q;
    case (state_q)
      ST_CLEAR: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          state_d = ST_HDR;
        end
      end
      ST_HDR: begin
        if (set_end) begin
          idx_d   = '0;
          state_d = ST_SEARCH;
        end else if (in_valid) begin
          grp_d   = hdr_grp;
          mem_d   = hdr_member;
          idx_d   = '0;
          state_d = ST_SAMP;
          if (hdr_member && !hdr_grp) n0_d = n0_q + 1'b1;
          if (hdr_member && hdr_grp)  n1_d = n1_q + 1'b1;
        end
      end
      ST_SAMP: begin
        if (in_valid) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            idx_d   = '0;
            state_d = ST_HDR;
          end
        end
      end
      ST_SEARCH: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          idx_d   = '0;
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (start) begin
      state_d = ST_CLEAR;
      idx_d   = '0;
      n0_d    = '0;
      n1_d    = '0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      grp_q   <= 1'b0;
      mem_q   <= 1'b0;
      n0_q    <= '0;
      n1_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      grp_q   <= grp_d;
      mem_q   <= mem_d;
      n0_q    <= n0_d;
      n1_q    <= n1_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic             we;
    logic [SUM_W-1:0] wd;
    assign we = clr_w || (acc_w && (grp_q == 1'(g)));
    assign wd = clr_w ? '0 : (rd_sum[g] + SUM_W'(in_data));
    dom_acc_bank #(
      .DEPTH (NSAMP),
      .W     (SUM_W),
      .IW    (IDX_W)
    ) u_bank (
      .clk     (clk),
      .wr_en   (we),
      .wr_idx  (idx_q),
      .wr_data (wd),
      .rd_idx  (idx_q),
      .rd_data (rd_sum[g])
    );
  end

  dom_peak_unit #(
    .SUM_W (SUM_W),
    .CNT_W (CNT_W),
    .IW    (IDX_W)
  ) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (state_q == ST_SEARCH),
    .first    (idx_q == '0),
    .idx      (idx_q),
    .s0       (rd_sum[0]),
    .s1       (rd_sum[1]),
    .n0       (n0_q),
    .n1       (n1_q),
    .best     (best),
    .best_idx (best_idx)
  );

  assign fin_en    = (state_q == ST_FIN);
  assign empty_grp = (n0_q == '0) || (n1_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= fin_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      invalid_q <= 1'b0;
      num_q     <= '0;
      den_q     <= '0;
      pidx_q    <= '0;
    end else if (fin_en) begin
      invalid_q <= empty_grp;
      num_q     <= empty_grp ? '0 : best;
      den_q     <= DEN_W'(n0_q) * DEN_W'(n1_q);
      pidx_q    <= empty_grp ? '0 : best_idx;
    end
  end

  assign done      = done_q;
  assign invalid   = invalid_q;
  assign score_num = num_q;
  assign score_den = den_q;
  assign peak_idx  = pidx_q;

endmodule

// File: rtl/dom_key_scorer_chk.sv
module dom_key_scorer_chk #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32,
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_ready,
  input logic             done,
  input logic             invalid,
  input logic [NUM_W-1:0] score_num,
  input logic [DEN_W-1:0] score_den,
  input logic [IDX_W-1:0] peak_idx
);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(score_num) && $stable(score_den) && $stable(peak_idx)) |-> done);

  // R4
  start_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !in_ready);

  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (score_num == '0 && peak_idx == '0 && score_den == '0));

  // R7
  valid_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !invalid) |-> (score_den != '0));

  // R9
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

endmodule

bind dom_key_scorer dom_key_scorer_chk #(
  .NUM_W (NUM_W),
  .DEN_W (DEN_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .in_ready  (in_ready),
  .done      (done),
  .invalid   (invalid),
  .score_num (score_num),
  .score_den (score_den),
  .peak_idx  (peak_idx)
);

// File: tb/dom_key_scorer_bench.sv
module dom_key_scorer_bench;

  localparam int NS   = 8;
  localparam int IW   = $clog2(NS);
  localparam int MAXT = 12;
  localparam int NTR  = 10;

  // {guess[19:12], bit_sel[11:9], hw_mode[8], seed[7:0]}
  localparam logic [19:0] VEC [6] = '{
    {8'h00, 3'd7, 1'b0, 8'd3},
    {8'h3c, 3'd0, 1'b0, 8'd11},
    {8'hae, 3'd4, 1'b0, 8'd29},
    {8'h5a, 3'd2, 1'b1, 8'd47},
    {8'hff, 3'd6, 1'b1, 8'd71},
    {8'h81, 3'd1, 1'b0, 8'd93}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, set_end, hw_mode, in_valid;
  logic [7:0]  guess;
  logic [2:0]  bit_sel;
  logic [15:0] in_data;
  logic        in_ready, done, invalid;
  logic [47:0] score_num;
  logic [31:0] score_den;
  logic [IW-1:0] peak_idx;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  inv_tab [256];
  logic [7:0]  tbyte [MAXT];
  logic [15:0] samp  [MAXT][NS];
  longint exp_num, exp_den, exp_idx;
  logic   exp_inv;

  always #2.5 clk = ~clk;

  dom_key_scorer #(.NSAMP(NS)) u_dom_key_scorer (
    .clk(clk), .rst_n(rst_n), .start(start), .set_end(set_end),
    .guess(guess), .bit_sel(bit_sel), .hw_mode(hw_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .done(done), .invalid(invalid), .score_num(score_num),
    .score_den(score_den), .peak_idx(peak_idx)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  // forward S-box by brute-force inverse search, then inverted into a table
  task automatic build_inv();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] iv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (tb_mul(8'(v), 8'(y)) == 8'h01) iv = 8'(y);
      s = iv ^ {iv[6:0], iv[7]} ^ {iv[5:0], iv[7:6]} ^ {iv[4:0], iv[7:5]}
            ^ {iv[3:0], iv[7:4]} ^ 8'h63;
      inv_tab[s] = 8'(v);
    end
  endtask

  task automatic model(input int ntr);
    longint s0 [NS];
    longint s1 [NS];
    longint n0 = 0;
    longint n1 = 0;
    for (int t = 0; t < NS; t++) begin s0[t] = 0; s1[t] = 0; end
    for (int k = 0; k < ntr; k++) begin
      logic [7:0] sv = inv_tab[tbyte[k] ^ guess];
      int w = $countones(sv);
      int g;
      if (hw_mode && w == 4) continue;
      g = hw_mode ? int'(w > 4) : int'(sv[bit_sel]);
      if (g == 0) n0++; else n1++;
      for (int t = 0; t < NS; t++) begin
        if (g == 0) s0[t] += samp[k][t]; else s1[t] += samp[k][t];
      end
    end
    exp_inv = (n0 == 0) || (n1 == 0);
    exp_den = n0 * n1;
    exp_num = 0;
    exp_idx = 0;
    if (!exp_inv) begin
      for (int t = 0; t < NS; t++) begin
        longint d = s0[t] * n1 - s1[t] * n0;
        if (d < 0) d = -d;
        if (t == 0 || d > exp_num) begin exp_num = d; exp_idx = t; end
      end
    end
  endtask

  task automatic send_beat(input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_trace(input int k);
    send_beat({8'h00, tbyte[k]});
    for (int t = 0; t < NS; t++) send_beat(samp[k][t]);
  endtask

  task automatic do_start();
    int cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!in_ready && cnt < 1000) begin @(negedge clk); cnt++; end
    chk("R4 clear latency", cnt, NS);
  endtask

  task automatic finish_set();
    int cnt = 0;
    logic [47:0] held;
    @(negedge clk); set_end = 1'b1;
    @(negedge clk); set_end = 1'b0;
    while (!done && cnt < 1000) begin @(negedge clk); cnt++; end
    chk("R8 done latency", cnt, NS + 1);
    chk("R7 invalid", invalid, exp_inv);
    chk("R6 score_num", score_num, exp_num);
    chk("R6 score_den", score_den, exp_den);
    chk("R6 peak_idx", peak_idx, exp_idx);
    held = score_num;
    @(negedge clk);
    chk("R8 done pulse ends", done, 0);
    chk("R8 result held", score_num, held);
    chk("R9 ready low after search", in_ready, 0);
  endtask

  task automatic run_pass(input int ntr);
    model(ntr);
    do_start();
    for (int k = 0; k < ntr; k++) send_trace(k);
    finish_set();
  endtask

  task automatic flat(input int k, input logic [7:0] b, input logic [15:0] v);
    tbyte[k] = b;
    for (int t = 0; t < NS; t++) samp[k][t] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; set_end = 1'b0; in_valid = 1'b0;
    in_data = '0; guess = '0; bit_sel = '0; hw_mode = 1'b0;
    build_inv();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset in_ready", in_ready, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset score", score_num, 0);
    chk("R1 table InvSbox(00)", inv_tab[8'h00], 8'h52);

    // table-driven passes
    for (int v = 0; v < 6; v++) begin
      guess   = VEC[v][19:12];
      bit_sel = VEC[v][11:9];
      hw_mode = VEC[v][8];
      for (int k = 0; k < NTR; k++) begin
        tbyte[k] = 8'((VEC[v][7:0] * 17) + k * 53 + k * k * 7);
        for (int t = 0; t < NS; t++)
          samp[k][t] = 16'(((tbyte[k] * 37) + t * (k + 3) * 11 + VEC[v][7:0] * 5) & 16'h0fff);
      end
      run_pass(NTR);
    end

    // R1 R2: hand values, bytes map to selection 0x00 and 0xFF
    guess = 8'h5a; bit_sel = 3'd0; hw_mode = 1'b0;
    flat(0, 8'h63 ^ 8'h5a, 16'd10); samp[0][3] = 16'd50;
    flat(1, 8'h16 ^ 8'h5a, 16'd10);
    run_pass(2);
    chk("R1 R2 hand score", score_num, 40);
    chk("R2 hand index", peak_idx, 3);

    // R3: weight-4 trace (selection 0x0F) is dropped
    guess = 8'h00; hw_mode = 1'b1;
    flat(0, 8'h63, 16'd10); samp[0][3] = 16'd50;
    flat(1, 8'h16, 16'd10);
    flat(2, 8'h76, 16'd10); samp[2][6] = 16'd9999;
    run_pass(3);
    chk("R3 weight4 dropped score", score_num, 40);
    chk("R3 weight4 dropped den", score_den, 1);

    // R6: tie between positions 1 and 5 keeps the lower one
    hw_mode = 1'b0; bit_sel = 3'd7;
    flat(0, 8'h63, 16'd100); samp[0][1] = 16'd120; samp[0][5] = 16'd80;
    flat(1, 8'h16, 16'd100);
    run_pass(2);
    chk("R6 tie index", peak_idx, 1);

    // R7: both traces in group 0
    flat(0, 8'h63, 16'd7);
    flat(1, 8'h7c, 16'd300);
    run_pass(2);
    chk("R7 empty group flag", invalid, 1);

    // R5: set_end during samples is ignored
    guess = 8'h00; bit_sel = 3'd0; hw_mode = 1'b0;
    flat(0, 8'h63, 16'd10); samp[0][3] = 16'd50;
    flat(1, 8'h16, 16'd10);
    model(2);
    do_start();
    send_trace(0);
    send_beat({8'h00, tbyte[1]});
    for (int t = 0; t < 3; t++) send_beat(samp[1][t]);
    @(negedge clk); set_end = 1'b1;
    @(negedge clk); set_end = 1'b0;
    begin
      int seen = 0;
      repeat (NS + 3) begin @(negedge clk); if (done) seen++; end
      chk("R5 mid-trace set_end ignored", seen, 0);
    end
    chk("R5 still accepting samples", in_ready, 1);
    for (int t = 3; t < NS; t++) send_beat(samp[1][t]);
    finish_set();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule